// File: doc/BRIEF.md
# Receive Byte Buffer with Address-Gated Visibility

This block is a 16-entry, byte-wide receive buffer. It sits between a radio deframer and a host processor. The deframer pushes bytes with a write strobe, and the host pops them through a read port. The host sees a fill count and two one-cycle interrupt events. The first is almost-full, with a threshold of 12 or 8 selected by a level input. The second is overflow, raised when a byte reaches a buffer that is already full.

When address filtering is enabled, a packet-start strobe opens a pending packet. Its bytes are stored and counted at once in an internal occupancy count, and that count drives almost-full. They stay out of the host-visible count, and they cannot be read, until an identifier-match strobe arrives. An identifier-reject strobe rolls the write position and the internal count back to where the packet began. The rest of that packet is then ignored until the next packet start. Because almost-full follows the internal count, it can fire while the host sees fewer bytes than the threshold. With a 12-byte threshold at 1 Mbps, the host has about 32 µs to respond.

A three-state controller governs visibility. OPEN means new bytes are visible at once. HOLD means the bytes of a packet are pending its identifier check. DROP means a rejected packet's remaining bytes are discarded. The transitions are:
- OPEN→HOLD on a packet start with filtering enabled.
- HOLD→OPEN on a match, or on a packet start with filtering off.
- HOLD→HOLD on a packet start with filtering on (restart).
- HOLD→DROP on a reject.
- DROP→HOLD or DROP→OPEN on the next packet start, depending on whether filtering is enabled.

Top module: `rx_filt_fifo`

## Requirements
- R1: After reset the visible count is 0, both event outputs are low and `rd_data` reads 0.
- R2: With filtering off, each stored byte raises `vis_cnt` by one in the cycle after its write. A read with `vis_cnt` > 0 lowers it by one and moves to the next byte in arrival order. A read with `vis_cnt` = 0 is ignored. `rd_data` shows the oldest visible byte, or 0 when none is visible.
- R3: The buffer holds 16 bytes. A write that arrives when the internal occupancy is 16 is not stored, leaves the contents and counts unchanged, and raises `ovf_pulse` for exactly one cycle.
- R4: `af_pulse` is high for one cycle after the write that takes the internal occupancy from below the threshold to at or above it. The threshold is 12 when `thr_sel`=0 and 8 when `thr_sel`=1.
- R5: `pkt_start` with `filt_en`=1 opens a pending packet. Its bytes, including one written in the same cycle, count toward the occupancy and almost-full, but not toward `vis_cnt`, and they are not readable.
- R6: `id_ok` during a pending packet makes all of its bytes visible, including a byte written in the same cycle.
- R7: `id_bad` during a pending packet discards its bytes, restoring the internal occupancy and write position. Later writes, including one in the same cycle, are ignored without raising overflow until the next `pkt_start`. That next `pkt_start` and a byte in its own cycle are accepted.
- R8: `pkt_start` during a pending packet discards the pending bytes and starts a new packet at the same position. It wins over `id_ok` and `id_bad` in the same cycle.
- R9: `id_bad` wins over `id_ok` in the same cycle. Both strobes are ignored when no packet is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write strobe from deframer |
| wr_data | input | 8 | Received byte |
| pkt_start | input | 1 | First byte of a new packet |
| filt_en | input | 1 | Address filtering enable (level) |
| id_ok | input | 1 | Identifier match strobe |
| id_bad | input | 1 | Identifier reject strobe |
| thr_sel | input | 1 | Almost-full threshold: 0 = 12, 1 = 8 |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest visible byte, 0 when none |
| vis_cnt | output | 5 | Host-visible byte count |
| af_pulse | output | 1 | Almost-full event, one cycle |
| ovf_pulse | output | 1 | Overflow event, one cycle |

## Verification
The hardest situation to reach from the ports is almost-full firing while the host sees fewer bytes than the threshold. It needs a committed packet sitting just below the threshold, then a read, and then a filtered packet whose first hidden byte makes the crossing. The stimulus table builds exactly that sequence with the 8-byte threshold. It then rejects the pending packet, writes into the dropped stream, and reopens without filtering, confirming that the visible count and the head byte survive. Directed runs cover the full/overflow boundary at the 12-byte threshold, restart of a pending packet, and same-cycle strobe priorities.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        S_OPEN = 2'd0,
        S_HOLD = 2'd1,
        S_DROP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          pkt_start,
    input  logic          filt_en,
    input  logic          id_ok,
    input  logic          id_bad,
    input  logic [CW-1:0] occ_q,
    output logic          rollback,
    output logic          enter_hold,
    output logic          wr_acc,
    output logic          ovf_ev,
    output logic [CW-1:0] occ_base,
    output logic [CW-1:0] pend_q
);
    rx_state_e     state_q, state_n;
    logic          commit, blocked, wr_try, full, hide;
    logic [CW-1:0] pend_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OPEN;
            pend_q  <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
        end
    end

    // next state and decisions
    always_comb begin
        state_n    = state_q;
        rollback   = 1'b0;
        commit     = 1'b0;
        blocked    = 1'b0;
        enter_hold = 1'b0;
        unique case (state_q)
            S_OPEN: begin
                if (pkt_start && filt_en) begin
                    state_n    = S_HOLD;
                    enter_hold = 1'b1;
                end
            end
            S_HOLD: begin
                if (pkt_start) begin
                    rollback   = 1'b1;
                    state_n    = filt_en ? S_HOLD : S_OPEN;
                    enter_hold = filt_en;
                end else if (id_bad) begin
                    rollback = 1'b1;
                    blocked  = 1'b1;
                    state_n  = S_DROP;
                end else if (id_ok) begin
                    commit  = 1'b1;
                    state_n = S_OPEN;
                end
            end
            S_DROP: begin
                if (pkt_start) begin
                    state_n    = filt_en ? S_HOLD : S_OPEN;
                    enter_hold = filt_en;
                end else begin
                    blocked = 1'b1;
                end
            end
            default: state_n = S_OPEN;
        endcase

        occ_base = rollback ? (occ_q - pend_q) : occ_q;
        full     = (occ_base == CW'(DEPTH));
        wr_try   = wr_en && !blocked;
        wr_acc   = wr_try && !full;
        ovf_ev   = wr_try && full;
        hide     = (state_n == S_HOLD);
        pend_n   = ((rollback || commit) ? '0 : pend_q) + CW'(wr_acc && hide);
    end

    AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DROP && !pkt_start) |=> (occ_q <= $past(occ_q))); // R7
    AST_OPEN_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPEN) |-> (pend_q == '0)); // R6
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rollback,
    input  logic          enter_hold,
    input  logic          wr_acc,
    input  logic          pop,
    input  logic [CW-1:0] occ_base,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] rptr_q,
    output logic [CW-1:0] occ_q,
    output logic [CW-1:0] occ_n
);
    logic [AW-1:0] wptr_q, mark_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        waddr = rollback ? mark_q : wptr_q;
        occ_n = occ_base + CW'(wr_acc) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            mark_q <= '0;
            rptr_q <= '0;
            occ_q  <= '0;
        end else begin
            wptr_q <= wr_acc ? bump(waddr) : waddr;
            if (enter_hold) mark_q <= waddr;
            if (pop) rptr_q <= bump(rptr_q);
            occ_q <= occ_n;
        end
    end

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(DEPTH)); // R3
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq #(
    parameter int CW    = 5,
    parameter int AF_HI = 12,
    parameter int AF_LO = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thr_sel,
    input  logic [CW-1:0] occ_q,
    input  logic [CW-1:0] occ_n,
    input  logic          ovf_ev,
    output logic          af_pulse,
    output logic          ovf_pulse
);
    logic [CW-1:0] thr;

    assign thr = thr_sel ? CW'(AF_LO) : CW'(AF_HI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_pulse  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            af_pulse  <= (occ_n >= thr) && (occ_q < thr);
            ovf_pulse <= ovf_ev;
        end
    end

    AST_AF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        af_pulse |=> !af_pulse); // R4
endmodule

// File: rtl/rx_filt_fifo.sv
module rx_filt_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AF_HI = 12,
    parameter int AF_LO = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pkt_start,
    input  logic          filt_en,
    input  logic          id_ok,
    input  logic          id_bad,
    input  logic          thr_sel,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] vis_cnt,
    output logic          af_pulse,
    output logic          ovf_pulse
);
    logic          rollback, enter_hold, wr_acc, ovf_ev, pop;
    logic [CW-1:0] occ_base, pend_q, occ_q, occ_n;
    logic [AW-1:0] waddr, rptr_q;
    logic [DW-1:0] head;

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pkt_start(pkt_start),
        .filt_en(filt_en), .id_ok(id_ok), .id_bad(id_bad), .occ_q(occ_q),
        .rollback(rollback), .enter_hold(enter_hold), .wr_acc(wr_acc),
        .ovf_ev(ovf_ev), .occ_base(occ_base), .pend_q(pend_q)
    );

    rxf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .rollback(rollback), .enter_hold(enter_hold),
        .wr_acc(wr_acc), .pop(pop), .occ_base(occ_base), .waddr(waddr),
        .rptr_q(rptr_q), .occ_q(occ_q), .occ_n(occ_n)
    );

    rxf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
        .raddr(rptr_q), .rdata(head)
    );

    rxf_irq #(.CW(CW), .AF_HI(AF_HI), .AF_LO(AF_LO)) u_irq (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .occ_q(occ_q),
        .occ_n(occ_n), .ovf_ev(ovf_ev), .af_pulse(af_pulse), .ovf_pulse(ovf_pulse)
    );

    assign vis_cnt = occ_q - pend_q;
    assign pop     = rd_en && (vis_cnt != '0);
    assign rd_data = (vis_cnt != '0) ? head : '0;

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ($past(occ_q) == CW'(DEPTH))); // R3
    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= occ_q); // R5
endmodule

// File: tb/rx_filt_fifo_tb.sv
module rx_filt_fifo_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, wr_en, pkt_start, filt_en, id_ok, id_bad, thr_sel, rd_en;
    logic [7:0] wr_data, rd_data;
    logic [4:0] vis_cnt;
    logic       af_pulse, ovf_pulse;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_filt_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pkt_start(pkt_start), .filt_en(filt_en), .id_ok(id_ok), .id_bad(id_bad),
        .thr_sel(thr_sel), .rd_en(rd_en), .rd_data(rd_data), .vis_cnt(vis_cnt),
        .af_pulse(af_pulse), .ovf_pulse(ovf_pulse)
    );

    // ctrl bits {wr,pkt,filt,ok,bad,rd,thr}, data, exp vis, af, ovf, head
    localparam logic [29:0] TAB [16] = '{
        {7'b1110001, 8'hA0, 5'd0, 1'b0, 1'b0, 8'h00},
        {7'b1010001, 8'hA1, 5'd0, 1'b0, 1'b0, 8'h00},
        {7'b1010001, 8'hA2, 5'd0, 1'b0, 1'b0, 8'h00},
        {7'b1010001, 8'hA3, 5'd0, 1'b0, 1'b0, 8'h00},
        {7'b1011001, 8'hA4, 5'd5, 1'b0, 1'b0, 8'hA0},
        {7'b1010001, 8'hA5, 5'd6, 1'b0, 1'b0, 8'hA0},
        {7'b1010001, 8'hA6, 5'd7, 1'b0, 1'b0, 8'hA0},
        {7'b1010001, 8'hA7, 5'd8, 1'b1, 1'b0, 8'hA0},
        {7'b0010011, 8'h00, 5'd7, 1'b0, 1'b0, 8'hA1},
        {7'b1110001, 8'hB0, 5'd7, 1'b1, 1'b0, 8'hA1},
        {7'b1010101, 8'hB1, 5'd7, 1'b0, 1'b0, 8'hA1},
        {7'b1010001, 8'hB2, 5'd7, 1'b0, 1'b0, 8'hA1},
        {7'b0010011, 8'h00, 5'd6, 1'b0, 1'b0, 8'hA2},
        {7'b1100001, 8'hC0, 5'd7, 1'b0, 1'b0, 8'hA2},
        {7'b1000001, 8'hC1, 5'd8, 1'b1, 1'b0, 8'hA2},
        {7'b0000001, 8'h00, 5'd8, 1'b0, 1'b0, 8'hA2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // inputs applied at a falling edge, outputs sampled at the next falling edge
    task automatic cyc(input logic [6:0] c, input logic [7:0] d);
        {wr_en, pkt_start, filt_en, id_ok, id_bad, rd_en, thr_sel} = c;
        wr_data = d;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {wr_en, pkt_start, filt_en, id_ok, id_bad, rd_en, thr_sel} = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 vis", vis_cnt, 0);
        chk("R1 af", af_pulse, 0);
        chk("R1 ovf", ovf_pulse, 0);
        chk("R1 rd_data", rd_data, 0);

        // table: R5 hidden bytes, R6 commit, R4 early almost-full, R7 reject and drop
        for (int i = 0; i < 16; i++) begin
            cyc(TAB[i][29:23], TAB[i][22:15]);
            chk($sformatf("R5/R6/R7 row %0d vis", i), vis_cnt, int'(TAB[i][14:10]));
            chk($sformatf("R4 row %0d af", i), af_pulse, int'(TAB[i][9]));
            chk($sformatf("R7 row %0d ovf", i), ovf_pulse, int'(TAB[i][8]));
            chk($sformatf("R5 row %0d head", i), rd_data, int'(TAB[i][7:0]));
        end

        // R3 and R4: fill to 16 at threshold 12, then overflow
        do_reset();
        for (int i = 0; i < 16; i++) begin
            cyc(7'b1000000, 8'(8'h10 + i));
            chk("R2 fill vis", vis_cnt, i + 1);
            chk("R4 af at 12", af_pulse, (i == 11) ? 1 : 0);
            chk("R3 no ovf", ovf_pulse, 0);
        end
        cyc(7'b1000000, 8'hEE);
        chk("R3 ovf pulse", ovf_pulse, 1);
        chk("R3 vis held", vis_cnt, 16);
        cyc(7'b0000000, 8'h00);
        chk("R3 ovf one cycle", ovf_pulse, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order", rd_data, 8'h10 + i);
            cyc(7'b0000010, 8'h00);
            chk("R2 pop vis", vis_cnt, 15 - i);
        end
        cyc(7'b0000010, 8'h00);
        chk("R2 empty read ignored", vis_cnt, 0);
        chk("R2 empty rd_data", rd_data, 0);

        // R8 restart wins over id_ok; R9 strobes ignored when open
        cyc(7'b1110000, 8'h50);
        cyc(7'b1010000, 8'h51);
        chk("R5 pending hidden", vis_cnt, 0);
        cyc(7'b1111000, 8'h60);
        chk("R8 restart hides", vis_cnt, 0);
        cyc(7'b0011000, 8'h00);
        chk("R6 commit vis", vis_cnt, 1);
        chk("R8 old packet gone", rd_data, 8'h60);
        cyc(7'b1010100, 8'h61);
        chk("R9 bad ignored when open", vis_cnt, 2);
        cyc(7'b0010010, 8'h00);
        chk("R9 head after pop", rd_data, 8'h61);
        cyc(7'b0010010, 8'h00);
        chk("R2 drained", vis_cnt, 0);

        // R9 reject beats match
        cyc(7'b1110000, 8'h70);
        cyc(7'b0011100, 8'h00);
        chk("R9 bad over ok", vis_cnt, 0);
        cyc(7'b1010000, 8'h71);
        chk("R7 dropped write", vis_cnt, 0);
        chk("R7 no ovf in drop", ovf_pulse, 0);
        cyc(7'b1100000, 8'h72);
        chk("R7 reopen vis", vis_cnt, 1);
        chk("R7 reopen head", rd_data, 8'h72);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule